// File: doc/BRIEF.md
# Complementary Dead-Time Output Stage

This block turns up to four raw pulse-width-modulated bits into complementary pin pairs. For every raw input it drives a main pin and, on the neighbouring pin, the complement of that signal. Each time the raw bit changes, both pins of the pair are held at the inactive level for a programmed number of clock ticks before the newly selected pin turns on. This gap lets one switch of a half bridge turn off before the other turns on. The gap therefore shortens the active phase of both the main and the complementary waveform.

The dead-time count comes from a run-time input. A pair samples a new value only while both of its pins are steady, so an interval that has already started always runs to its end. One polarity input selects which level counts as active, and the inactive level follows it. One disable bit per pair forces both of its pins to the inactive level. The raw waveform itself and any conversion from seconds to ticks are done outside this block. At a 10 ns clock, a count of 1 to 1023 covers gaps of 0.01 to 10.23 us.

Top module: `comp_deadband_stage`

## Requirements
- R1: Pair k drives main pin `pins[2k]` and complement pin `pins[2k+1]`. With a dead-time count of 0 and the pair enabled, the main pin repeats the raw bit two clock edges later and the complement pin is its inverse.
- R2: When `active_low` is 0, a pin is active at 1 and inactive at 0. When `active_low` is 1, all levels are inverted and the inactive level is 1. The polarity sampled at a clock edge applies to the pins from that edge on.
- R3: After every change of a pair's raw bit, both pins of that pair show the inactive level for exactly D consecutive cycles, where D is the pair's latched dead-time count (0 to 1023). After the gap, the newly selected pin turns active.
- R4: Let n be a clock edge and D the latched count. After edge n, the main pin is active only if the raw bit sampled at edges n-1-D through n-1 was 1 at all D+1 of them. The complement pin is active only if the raw bit was 0 at all of them. In every other case both pins are inactive.
- R5: A raw pulse that lasts D samples or fewer never activates the delayed pin. The main and complement pins of a pair are never active at the same time.
- R6: A pair captures `dead_ticks` only while neither of its dead-time intervals is running. A change of `dead_ticks` during an interval does not change that interval's length, and the new value applies to the next edge after the pair is steady again.
- R7: When `pair_off[k]` is 1 at a clock edge, both pins of pair k show the inactive level after that edge. The timing of the pair continues to run while it is disabled.
- R8: While `rst_n` is low, every pin shows the inactive level for the current `active_low` value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one tick of dead time per cycle |
| rst_n | input | 1 | Synchronous reset, active low |
| pwm_raw | input | PAIRS (4) | Raw modulated bit for each pair |
| dead_ticks | input | DT_W (10) | Dead-time length in clock ticks |
| active_low | input | 1 | 1 selects active-low pins |
| pair_off | input | PAIRS (4) | Per-pair disable; forces both pins of the pair inactive |
| pins | output | 2*PAIRS (8) | Main pin at even index, complement pin at the next odd index |

## Verification
If a pair's counter or phase holds a wrong value, the error shows at the pins within D+2 cycles of the next raw edge. It appears as a gap that is too short or too long, as a pin that activates during a short pulse, or as both pins of a pair active at once. The bench compares every pin on every cycle against the D+1-sample history rule, so such a fault is reported in the first cycle where it differs. A wrong latched dead-time value shows as a changed gap length on the first edge after the change of `dead_ticks`. A fault in the disable or polarity path appears one edge after that input changes.

// File: rtl/deadband_pkg.sv
// Package: shared types for the complementary dead-time stage.
// Assumes: nothing beyond IEEE 1800-2017.
package deadband_pkg;

    // Phase of one pin pair: steady low or high, or waiting out a gap
    typedef enum logic [1:0] {
        PH_LOW       = 2'd0,
        PH_HIGH      = 2'd1,
        PH_WAIT_LOW  = 2'd2,
        PH_WAIT_HIGH = 2'd3
    } phase_e;

    // True while a dead-time interval is running
    function automatic logic phase_waiting(input phase_e ph);
        return (ph == PH_WAIT_LOW) || (ph == PH_WAIT_HIGH);
    endfunction

endpackage

// File: rtl/deadband_pair_seq.sv
// Module: deadband_pair_seq
// Follows one raw PWM bit and decides, in logical (active-high) terms,
// which pin of the pair may be on. Every raw edge starts a gap of
// hold_q ticks with both pins off. hold_q is reloaded from dead_i only
// while the pair is steady.
// Assumes: raw_i is synchronous to clk; reset is synchronous, active low.
module deadband_pair_seq
    import deadband_pkg::*;
#(
    parameter int DT_W = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            raw_i,
    input  logic [DT_W-1:0] dead_i,
    output logic            main_o,
    output logic            comp_o
);

    localparam logic [DT_W-1:0] ONE  = DT_W'(1);
    localparam logic [DT_W-1:0] ZERO = '0;

    logic            prev_q;
    phase_e          phase_q, phase_d;
    logic [DT_W-1:0] cnt_q, cnt_d;
    logic [DT_W-1:0] hold_q;
    logic            edge_w;
    logic            steady_w;

    assign edge_w   = raw_i ^ prev_q;
    assign steady_w = !phase_waiting(phase_q);

    // Next phase and count: restart the gap on an edge, else count it down
    always_comb begin
        phase_d = phase_q;
        cnt_d   = cnt_q;
        if (edge_w) begin
            if (hold_q == ZERO) begin
                phase_d = raw_i ? PH_HIGH : PH_LOW;
                cnt_d   = ZERO;
            end else begin
                phase_d = raw_i ? PH_WAIT_HIGH : PH_WAIT_LOW;
                cnt_d   = hold_q - ONE;
            end
        end else if (phase_waiting(phase_q)) begin
            if (cnt_q == ZERO) begin
                phase_d = (phase_q == PH_WAIT_HIGH) ? PH_HIGH : PH_LOW;
            end else begin
                cnt_d = cnt_q - ONE;
            end
        end
    end

    // State registers: previous raw sample, phase and count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q  <= 1'b0;
            phase_q <= PH_WAIT_LOW;
            cnt_q   <= ZERO;
        end else begin
            prev_q  <= raw_i;
            phase_q <= phase_d;
            cnt_q   <= cnt_d;
        end
    end

    // Dead-time latch: capture a new length only between intervals
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '1;
        end else if (steady_w) begin
            hold_q <= dead_i;
        end
    end

    assign main_o = (phase_q == PH_HIGH);
    assign comp_o = (phase_q == PH_LOW);

    // R3: a raw edge with a non-zero gap turns both pins off next cycle
    assert_dead_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_w && hold_q != ZERO) |=> (!main_o && !comp_o));

    // R5: the main pin is on only after a raw sample of 1
    assert_main_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
        main_o |-> prev_q);

    // R5: the complement pin is on only after a raw sample of 0
    assert_comp_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
        comp_o |-> !prev_q);

    // R6: the latched length does not move while an interval runs
    assert_hold_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!steady_w && !$past(steady_w)) |-> $stable(hold_q));

endmodule

// File: rtl/deadband_pin_drive.sv
// Module: deadband_pin_drive
// Registers the two pins of a pair. It applies the disable and the
// polarity, so a disabled pair shows the inactive level on both pins.
// Assumes: main_i and comp_i are never both high; reset synchronous.
module deadband_pin_drive (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       main_i,
    input  logic       comp_i,
    input  logic       off_i,
    input  logic       pol_i,
    output logic [1:0] pins_o
);

    logic [1:0] pins_q;

    // Pin register: mask with the disable, then apply the polarity
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pins_q <= {2{pol_i}};
        end else begin
            pins_q <= {comp_i & ~off_i, main_i & ~off_i} ^ {2{pol_i}};
        end
    end

    assign pins_o = pins_q;

    // R7: a disable bit sampled at an edge leaves both pins inactive
    assert_off_forces_R7: assert property (@(posedge clk) disable iff (!rst_n)
        off_i |=> (pins_q == {2{$past(pol_i)}}));

    // R5: never both pins active at once
    assert_no_overlap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !off_i |=> !((pins_q[0] != $past(pol_i)) && (pins_q[1] != $past(pol_i))));

endmodule

// File: rtl/comp_deadband_stage.sv
// Module: comp_deadband_stage (top)
// Drives PAIRS complementary pin pairs from PAIRS raw PWM bits. Each
// pair inserts a dead time after every raw edge, follows the polarity
// input and can be disabled.
// Assumes: all inputs are synchronous to clk; one dead-time tick is one cycle.
module comp_deadband_stage #(
    parameter int PAIRS = 4,
    parameter int DT_W  = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PAIRS-1:0]   pwm_raw,
    input  logic [DT_W-1:0]    dead_ticks,
    input  logic               active_low,
    input  logic [PAIRS-1:0]   pair_off,
    output logic [2*PAIRS-1:0] pins
);

    localparam int PINS = 2 * PAIRS;

    logic [PAIRS-1:0] main_w;
    logic [PAIRS-1:0] comp_w;
    logic [PINS-1:0]  pins_w;

    // One sequencer and one pin driver per pair
    for (genvar k = 0; k < PAIRS; k++) begin : g_pair
        deadband_pair_seq #(.DT_W(DT_W)) u_seq (
            .clk    (clk),
            .rst_n  (rst_n),
            .raw_i  (pwm_raw[k]),
            .dead_i (dead_ticks),
            .main_o (main_w[k]),
            .comp_o (comp_w[k])
        );

        deadband_pin_drive u_drv (
            .clk    (clk),
            .rst_n  (rst_n),
            .main_i (main_w[k]),
            .comp_i (comp_w[k]),
            .off_i  (pair_off[k]),
            .pol_i  (active_low),
            .pins_o (pins_w[2*k+1 : 2*k])
        );
    end

    assign pins = pins_w;

endmodule

// File: tb/sim_comp_deadband_stage.sv
module sim_comp_deadband_stage;

    localparam int CLK_PERIOD = 10;
    localparam int PAIRS      = 4;
    localparam int DT_W       = 10;

    logic               clk = 1'b0;
    logic               rst_n;
    logic [PAIRS-1:0]   pwm_raw;
    logic [DT_W-1:0]    dead_ticks;
    logic               active_low;
    logic [PAIRS-1:0]   pair_off;
    logic [2*PAIRS-1:0] pins;

    int          n_checks = 0;
    int          n_fails  = 0;
    logic [15:0] hist [PAIRS];
    logic [PAIRS-1:0] off_s;

    always #(CLK_PERIOD/2) clk = ~clk;

    comp_deadband_stage #(.PAIRS(PAIRS), .DT_W(DT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .pwm_raw(pwm_raw), .dead_ticks(dead_ticks),
        .active_low(active_low), .pair_off(pair_off), .pins(pins)
    );

    task automatic check(input string tag, input int act, input int exp, input string what);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Drive raw and disable, let one edge sample them, record history
    task automatic step(input logic [PAIRS-1:0] raw, input logic [PAIRS-1:0] off);
        pwm_raw  = raw;
        pair_off = off;
        @(posedge clk);
        for (int k = 0; k < PAIRS; k++) hist[k] = {hist[k][14:0], raw[k]};
        off_s = off;
        @(negedge clk);
    endtask

    // Expected pin pair from the D+1 sample rule (hist[1] is edge n-1)
    function automatic logic [1:0] expect_pair(input int k, input int d, input logic pol);
        logic m, c;
        m = 1'b1;
        c = 1'b1;
        for (int j = 1; j <= d + 1; j++) begin
            if (!hist[k][j]) m = 1'b0;
            if (hist[k][j])  c = 1'b0;
        end
        if (off_s[k]) begin
            m = 1'b0;
            c = 1'b0;
        end
        return {c, m} ^ {2{pol}};
    endfunction

    // Count cycles with both pins of pair 0 off until the wanted pin turns on
    task automatic gap_until(input int want_bit, input logic raw0, output int gap);
        gap = 0;
        for (int i = 0; i < 40; i++) begin
            if (pins[want_bit]) break;
            if (pins[1:0] == 2'b00) gap++;
            step({3'b000, raw0}, '0);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fails++;
        $display("FAIL watchdog R1 actual=hung expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        int gap;
        int mains;
        int both;
        int dlist [5];
        dlist = '{0, 1, 2, 3, 5};
        rst_n = 1'b0;
        pwm_raw = '0;
        dead_ticks = 10'd2;
        active_low = 1'b0;
        pair_off = '0;
        off_s = '0;
        for (int k = 0; k < PAIRS; k++) hist[k] = '0;

        // R8: reset shows the inactive level for each polarity
        repeat (3) @(negedge clk);
        check("R8", int'(pins), 0, "reset pins active-high");
        active_low = 1'b1;
        @(negedge clk);
        check("R8", int'(pins), 255, "reset pins active-low");
        active_low = 1'b0;
        rst_n = 1'b1;
        repeat (12) step('0, '0);

        // R1 R2 R4 R7: sweep of gap lengths, polarities, pulse shapes, disables
        for (int p = 0; p < 2; p++) begin
            for (int di = 0; di < 5; di++) begin
                int d;
                d = dlist[di];
                active_low = p[0];
                dead_ticks = DT_W'(d);
                repeat (12) step('0, '0);
                for (int c = 0; c < 120; c++) begin
                    logic [PAIRS-1:0] raw;
                    logic [PAIRS-1:0] off;
                    for (int k = 0; k < PAIRS; k++)
                        raw[k] = (((c * (k + 1)) / (d + 3 + k)) % 2) == 1;
                    off = ((c % 29) >= 24) ? PAIRS'(1 << (c % 4)) : '0;
                    step(raw, off);
                    for (int k = 0; k < PAIRS; k++) begin
                        string tag;
                        if (off_s[k])    tag = "R7";
                        else if (d == 0) tag = "R1";
                        else if (p == 1) tag = "R2";
                        else             tag = "R4";
                        check(tag, int'(pins[2*k +: 2]), int'(expect_pair(k, d, p[0])),
                              $sformatf("pair %0d d=%0d cycle %0d", k, d, c));
                    end
                end
            end
        end

        // R3: gap length after a rising and after a falling edge
        active_low = 1'b0;
        dead_ticks = 10'd3;
        repeat (12) step('0, '0);
        step(4'b0001, '0);
        gap_until(0, 1'b1, gap);
        check("R3", gap, 3, "gap after rise");
        repeat (5) step(4'b0001, '0);
        step(4'b0000, '0);
        gap_until(1, 1'b0, gap);
        check("R3", gap, 3, "gap after fall");

        // R5: a pulse of D samples never turns the main pin on
        repeat (8) step('0, '0);
        mains = 0;
        both = 0;
        for (int i = 0; i < 14; i++) begin
            step({3'b000, (i < 3) ? 1'b1 : 1'b0}, '0);
            if (pins[0]) mains++;
            if (pins[0] && pins[1]) both++;
        end
        check("R5", mains, 0, "main pin during short pulse");
        check("R5", both, 0, "overlap during short pulse");

        // R6: a new count during an interval waits for the next edge
        dead_ticks = 10'd4;
        repeat (12) step('0, '0);
        step(4'b0001, '0);
        dead_ticks = 10'd1;
        gap_until(0, 1'b1, gap);
        check("R6", gap, 4, "interval keeps old count");
        repeat (6) step(4'b0001, '0);
        step(4'b0000, '0);
        gap_until(1, 1'b0, gap);
        check("R6", gap, 1, "next interval uses new count");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule